// File: doc/BRIEF.md
# Three-Level DMA Address Sequencer

This block steps through one transfer description and emits one source/destination address pair for each array of bytes. A transfer has three nested levels. An array is a run of bytes of a given length. A frame is a group of arrays. A block is a group of frames. The source side and the destination side each have their own signed offset between arrays and their own signed offset between frames. Either side can also be pinned to a fixed address, which suits a peripheral FIFO. The downstream data mover takes each emitted pair and moves the bytes of that array.

Software writes transfer descriptions through one load port. One load index selects the active description. Every other index writes an entry of a small link table. A sync pulse releases work on the active description: one array, the rest of the current frame, or the rest of the block, as the description's mode selects. When the last array of the block is accepted, the active description is replaced by the table entry it links to, or cleared to a null state if its link is the null value. At the same moment the block can send a one-cycle chain pulse that names another channel. A sync that cannot be served produces a one-cycle missed-event pulse.

Top module: `dma3d_seq`

## Requirements
- R1: While reset is held low and afterwards, out_valid, ev_miss and chain_vld are 0 until the first sync. The active description is null after reset, so a sync issued right after reset gives ev_miss and no beat.
- R2: ld_data holds the description packed MSB first as: src_addr[32], dst_addr[32], arr_bytes[16], frm_arrays[16], blk_frames[16], src_aofs[16], dst_aofs[16], src_fofs[16], dst_fofs[16], link[3], mode[2], src_fix, dst_fix, chain_en, chain_ch[6]. A write with ld_idx = 7 replaces the active description and restarts its walk. A write with ld_idx 0..6 updates only that link-table entry and leaves the beats of the active walk unchanged.
- R3: Each beat carries one array: out_len equals arr_bytes. Beats run through all arrays of a frame, then through frames in order, until blk_frames frames are done.
- R4: In increment mode, each array after the first in a frame has its address moved by that side's signed 16-bit array offset.
- R5: The first array of each following frame sits at the previous frame's first address plus that side's signed 16-bit frame offset.
- R6: A side with its fix bit set keeps its start address for every beat of the block. The fix bit of each side is independent of the other side.
- R7: The mode field selects how much one sync releases: 0 releases one array, 1 releases the rest of the current frame, 2 or 3 release the rest of the block. out_valid is 0 in the cycle after the last released beat is accepted.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_src, out_dst and out_len hold.
- R9: When the last array of a block is accepted, the active description becomes link-table entry link, restarted at its beginning. A link of 7 leaves the active description null, and later syncs are missed.
- R10: If chain_en is set, chain_vld pulses for one cycle in the cycle after the block's last beat is accepted, with chain_ch equal to the description's chain_ch. If chain_en is clear, no pulse is produced.
- R11: A sync that arrives while the active description is null, while beats are still being released, or in the same cycle as an active load, produces ev_miss for one cycle in the next cycle and starts no beats.
- R12: A sync that is accepted makes out_valid 1 in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Description write strobe |
| ld_idx | input | 3 | Target: 7 = active, 0..6 = link-table entry |
| ld_data | input | 190 | Packed description |
| ev_sync | input | 1 | Sync event pulse |
| out_valid | output | 1 | Address beat available |
| out_ready | input | 1 | Consumer accepts the beat |
| out_src | output | 32 | Source address of the array |
| out_dst | output | 32 | Destination address of the array |
| out_len | output | 16 | Array length in bytes |
| ev_miss | output | 1 | One-cycle missed-sync pulse |
| chain_vld | output | 1 | One-cycle chain trigger |
| chain_ch | output | 6 | Channel to trigger |

## Verification
The assertions assume that the active description is never rewritten while a beat is waiting. For this reason the stall-hold and fixed-address properties exclude cycles in which ld_valid is high. The stimulus loads a new active description only after a burst has drained.

The random descriptions keep counts small (up to 64 bytes, 4 arrays and 3 frames) and cover every mode, fix combination, link value and chain setting. Syncs are issued only after the previous burst has ended, except in the directed busy case. Ready is randomised, so stalls happen often.

// File: rtl/dma3d_pkg.sv
// Shared widths, description layout and address helpers for the
// three-level DMA address sequencer. Assumes 16-bit signed offsets.
package dma3d_pkg;
    localparam int ADDR_W    = 32;
    localparam int CNT_W     = 16;
    localparam int OFS_W     = 16;
    localparam int LINK_W    = 3;
    localparam int CH_W      = 6;
    localparam int TBL_DEPTH = (1 << LINK_W) - 1;
    localparam logic [LINK_W-1:0] LINK_NULL = '1;

    typedef enum logic [1:0] {
        SYNC_ARRAY = 2'd0,
        SYNC_FRAME = 2'd1,
        SYNC_BLOCK = 2'd2,
        SYNC_ALL   = 2'd3
    } sync_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] src_addr;
        logic [ADDR_W-1:0] dst_addr;
        logic [CNT_W-1:0]  arr_bytes;
        logic [CNT_W-1:0]  frm_arrays;
        logic [CNT_W-1:0]  blk_frames;
        logic [OFS_W-1:0]  src_aofs;
        logic [OFS_W-1:0]  dst_aofs;
        logic [OFS_W-1:0]  src_fofs;
        logic [OFS_W-1:0]  dst_fofs;
        logic [LINK_W-1:0] link;
        sync_mode_e        mode;
        logic              src_fix;
        logic              dst_fix;
        logic              chain_en;
        logic [CH_W-1:0]   chain_ch;
    } dma3d_set_t;

    localparam int SET_W = $bits(dma3d_set_t);

    // A description with any zero count has nothing to move.
    function automatic logic set_is_null(dma3d_set_t s);
        return (s.arr_bytes == '0) || (s.frm_arrays == '0) || (s.blk_frames == '0);
    endfunction

    // Advance an address by a signed offset unless the side is fixed.
    function automatic logic [ADDR_W-1:0] addr_step(logic [ADDR_W-1:0] a,
                                                     logic [OFS_W-1:0] ofs,
                                                     logic hold);
        return hold ? a : a + ADDR_W'($signed(ofs));
    endfunction
endpackage

// File: rtl/dma3d_set_table.sv
// Link table: holds TBL_DEPTH descriptions written through the load port
// and reads one out by link index. The null link index reads as all zeros.
module dma3d_set_table
    import dma3d_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LINK_W-1:0] wr_idx,
    input  dma3d_set_t        wr_set,
    input  logic [LINK_W-1:0] rd_idx,
    output dma3d_set_t        rd_set
);
    dma3d_set_t ent [TBL_DEPTH];

    // Store a description into the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TBL_DEPTH; i++) ent[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < TBL_DEPTH; i++)
                if (wr_idx == LINK_W'(i)) ent[i] <= wr_set;
        end
    end

    // Select the linked entry, or a null description for the null link.
    always_comb begin
        rd_set = '0;
        for (int i = 0; i < TBL_DEPTH; i++)
            if (rd_idx == LINK_W'(i)) rd_set = ent[i];
    end
endmodule

// File: rtl/dma3d_walker.sv
// Holds the active description and walks its three levels. Each step
// moves to the next array. The final step reloads from the linked set.
// Assumes step is only raised while the description is non-null.
module dma3d_walker
    import dma3d_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_act,
    input  dma3d_set_t        load_set,
    input  logic              step,
    input  dma3d_set_t        link_set,
    output logic [LINK_W-1:0] link_idx,
    output logic [ADDR_W-1:0] cur_src,
    output logic [ADDR_W-1:0] cur_dst,
    output logic [CNT_W-1:0]  cur_len,
    output sync_mode_e        mode,
    output logic              chain_en,
    output logic [CH_W-1:0]   chain_ch,
    output logic              src_fix,
    output logic              is_null,
    output logic              frame_end,
    output logic              block_end
);
    dma3d_set_t        act;
    logic [CNT_W-1:0]  arr_left;
    logic [CNT_W-1:0]  frm_left;
    logic [ADDR_W-1:0] frm_src;
    logic [ADDR_W-1:0] frm_dst;
    logic              restart;
    dma3d_set_t        nxt_set;
    logic [ADDR_W-1:0] nfrm_src;
    logic [ADDR_W-1:0] nfrm_dst;

    // Choose the reload source and the next frame start addresses.
    always_comb begin
        restart  = load_act || (step && block_end);
        nxt_set  = load_act ? load_set : link_set;
        nfrm_src = addr_step(frm_src, act.src_fofs, act.src_fix);
        nfrm_dst = addr_step(frm_dst, act.dst_fofs, act.dst_fix);
    end

    // Position and address registers for the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act      <= '0;
            arr_left <= '0;
            frm_left <= '0;
            cur_src  <= '0;
            cur_dst  <= '0;
            frm_src  <= '0;
            frm_dst  <= '0;
        end else if (restart) begin
            act      <= nxt_set;
            arr_left <= nxt_set.frm_arrays;
            frm_left <= nxt_set.blk_frames;
            cur_src  <= nxt_set.src_addr;
            cur_dst  <= nxt_set.dst_addr;
            frm_src  <= nxt_set.src_addr;
            frm_dst  <= nxt_set.dst_addr;
        end else if (step) begin
            if (frame_end) begin
                arr_left <= act.frm_arrays;
                frm_left <= frm_left - 1'b1;
                frm_src  <= nfrm_src;
                frm_dst  <= nfrm_dst;
                cur_src  <= nfrm_src;
                cur_dst  <= nfrm_dst;
            end else begin
                arr_left <= arr_left - 1'b1;
                cur_src  <= addr_step(cur_src, act.src_aofs, act.src_fix);
                cur_dst  <= addr_step(cur_dst, act.dst_aofs, act.dst_fix);
            end
        end
    end

    // Expose position flags and description fields.
    always_comb begin
        frame_end = (arr_left == CNT_W'(1));
        block_end = frame_end && (frm_left == CNT_W'(1));
        is_null   = set_is_null(act);
        link_idx  = act.link;
        cur_len   = act.arr_bytes;
        mode      = act.mode;
        chain_en  = act.chain_en;
        chain_ch  = act.chain_ch;
        src_fix   = act.src_fix;
    end
endmodule

// File: rtl/dma3d_sync_ctrl.sv
// Turns sync pulses into bursts of beats, sized by the sync mode. Flags
// syncs that cannot be served and issues the chain pulse at block end.
// Assumes the walker's flags describe the beat currently offered.
module dma3d_sync_ctrl
    import dma3d_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_sync,
    input  logic            abort,
    input  logic            is_null,
    input  sync_mode_e      mode,
    input  logic            frame_end,
    input  logic            block_end,
    input  logic            fire,
    input  logic            chain_en,
    input  logic [CH_W-1:0] chain_ch_in,
    output logic            busy,
    output logic            ev_miss,
    output logic            chain_vld,
    output logic [CH_W-1:0] chain_ch
);
    logic stop;
    logic refuse;

    // A burst ends on its last released beat. A sync is refused when busy, null or loading.
    always_comb begin
        stop   = (mode == SYNC_ARRAY) || ((mode == SYNC_FRAME) && frame_end) || block_end;
        refuse = busy || is_null || abort;
    end

    // Burst state, missed-event pulse and chain pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            ev_miss   <= 1'b0;
            chain_vld <= 1'b0;
            chain_ch  <= '0;
        end else begin
            ev_miss   <= ev_sync && refuse;
            chain_vld <= fire && block_end && chain_en;
            if (fire && block_end && chain_en) chain_ch <= chain_ch_in;
            if (abort)                   busy <= 1'b0;
            else if (fire && stop)       busy <= 1'b0;
            else if (ev_sync && !refuse) busy <= 1'b1;
        end
    end
endmodule

// File: rtl/dma3d_seq.sv
// Top of the three-level DMA address sequencer. Splits the load port
// between the active description and the link table. The walker holds the
// position, the control releases bursts. One beat per array.
module dma3d_seq
    import dma3d_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [LINK_W-1:0] ld_idx,
    input  logic [SET_W-1:0]  ld_data,
    input  logic              ev_sync,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_src,
    output logic [ADDR_W-1:0] out_dst,
    output logic [CNT_W-1:0]  out_len,
    output logic              ev_miss,
    output logic              chain_vld,
    output logic [CH_W-1:0]   chain_ch
);
    logic              load_act;
    logic              tbl_wr;
    logic              fire;
    logic              busy;
    dma3d_set_t        ld_set;
    dma3d_set_t        link_set;
    logic [LINK_W-1:0] link_idx;
    sync_mode_e        act_mode;
    logic              act_chain_en;
    logic [CH_W-1:0]   act_chain_ch;
    logic              act_src_fix;
    logic              act_null;
    logic              frm_end;
    logic              blk_end;

    // Decode the load target and the beat handshake.
    always_comb begin
        ld_set    = dma3d_set_t'(ld_data);
        load_act  = ld_valid && (ld_idx == LINK_NULL);
        tbl_wr    = ld_valid && (ld_idx != LINK_NULL);
        out_valid = busy;
        fire      = busy && out_ready;
    end

    dma3d_set_table u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_wr),
        .wr_idx (ld_idx),
        .wr_set (ld_set),
        .rd_idx (link_idx),
        .rd_set (link_set)
    );

    dma3d_walker u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_act  (load_act),
        .load_set  (ld_set),
        .step      (fire),
        .link_set  (link_set),
        .link_idx  (link_idx),
        .cur_src   (out_src),
        .cur_dst   (out_dst),
        .cur_len   (out_len),
        .mode      (act_mode),
        .chain_en  (act_chain_en),
        .chain_ch  (act_chain_ch),
        .src_fix   (act_src_fix),
        .is_null   (act_null),
        .frame_end (frm_end),
        .block_end (blk_end)
    );

    dma3d_sync_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_sync     (ev_sync),
        .abort       (load_act),
        .is_null     (act_null),
        .mode        (act_mode),
        .frame_end   (frm_end),
        .block_end   (blk_end),
        .fire        (fire),
        .chain_en    (act_chain_en),
        .chain_ch_in (act_chain_ch),
        .busy        (busy),
        .ev_miss     (ev_miss),
        .chain_vld   (chain_vld),
        .chain_ch    (chain_ch)
    );
endmodule

// File: rtl/dma3d_seq_chk.sv
// Property checker for the sequencer, bound into every instance of the top.
module dma3d_seq_chk
    import dma3d_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ld_valid,
    input logic              ev_sync,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_src,
    input logic [ADDR_W-1:0] out_dst,
    input logic [CNT_W-1:0]  out_len,
    input logic              ev_miss,
    input logic              chain_vld,
    input logic              is_null,
    input logic              src_fix,
    input logic              block_end
);
    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !ld_valid |=> out_valid && $stable(out_src) && $stable(out_dst) && $stable(out_len)); // R8
    AST_NO_BEAT_WHEN_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        is_null |-> !out_valid); // R11
    AST_MISS_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        ev_miss |-> $past(ev_sync)); // R11
    AST_BUSY_SYNC_MISSED: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sync && out_valid |=> ev_miss); // R11
    AST_CHAIN_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        chain_vld |-> $past(out_valid && out_ready)); // R10
    AST_START_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(ev_sync)); // R12
    AST_FIXED_SRC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && src_fix && !block_end && !ld_valid |=> out_src == $past(out_src)); // R6
endmodule

bind dma3d_seq dma3d_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (ld_valid),
    .ev_sync   (ev_sync),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_src   (out_src),
    .out_dst   (out_dst),
    .out_len   (out_len),
    .ev_miss   (ev_miss),
    .chain_vld (chain_vld),
    .is_null   (act_null),
    .src_fix   (act_src_fix),
    .block_end (blk_end)
);

// File: tb/dma3d_seq_test.sv
`timescale 1ns/1ps
module dma3d_seq_test;
    import dma3d_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_valid = 1'b0;
    logic [LINK_W-1:0] ld_idx = '0;
    logic [SET_W-1:0]  ld_data = '0;
    logic              ev_sync = 1'b0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [ADDR_W-1:0] out_src;
    logic [ADDR_W-1:0] out_dst;
    logic [CNT_W-1:0]  out_len;
    logic              ev_miss;
    logic              chain_vld;
    logic [CH_W-1:0]   chain_ch;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    dma3d_set_t mset;
    dma3d_set_t mtbl [TBL_DEPTH];
    int mb = 0;
    int mc = 0;

    always #2.5 clk = ~clk;

    dma3d_seq uut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_data(ld_data),
        .ev_sync(ev_sync), .out_valid(out_valid), .out_ready(out_ready), .out_src(out_src),
        .out_dst(out_dst), .out_len(out_len), .ev_miss(ev_miss), .chain_vld(chain_vld),
        .chain_ch(chain_ch)
    );

    task automatic chk(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    function automatic bit m_null(dma3d_set_t s);
        return (s.arr_bytes == 0) || (s.frm_arrays == 0) || (s.blk_frames == 0);
    endfunction

    function automatic logic [31:0] exp_addr(logic [31:0] base, logic [15:0] aofs,
                                             logic [15:0] fofs, logic fix, int b, int c);
        int t;
        if (fix) return base;
        t = int'($signed(fofs)) * c + int'($signed(aofs)) * b;
        return base + 32'(t);
    endfunction

    function automatic int burst_len();
        if (m_null(mset)) return 0;
        if (mset.mode == SYNC_ARRAY) return 1;
        if (mset.mode == SYNC_FRAME) return int'(mset.frm_arrays) - mb;
        return (int'(mset.blk_frames) - mc - 1) * int'(mset.frm_arrays) + (int'(mset.frm_arrays) - mb);
    endfunction

    function automatic dma3d_set_t rand_set();
        dma3d_set_t s;
        s.src_addr   = $urandom;
        s.dst_addr   = $urandom;
        s.arr_bytes  = 16'(1 + $urandom % 64);
        s.frm_arrays = 16'(1 + $urandom % 4);
        s.blk_frames = 16'(1 + $urandom % 3);
        s.src_aofs   = 16'($urandom);
        s.dst_aofs   = 16'($urandom);
        s.src_fofs   = 16'($urandom);
        s.dst_fofs   = 16'($urandom);
        s.link       = 3'($urandom);
        s.mode       = sync_mode_e'(2'($urandom));
        s.src_fix    = 1'($urandom);
        s.dst_fix    = 1'($urandom);
        s.chain_en   = 1'($urandom);
        s.chain_ch   = 6'($urandom);
        return s;
    endfunction

    task automatic load(input logic [2:0] idx, input dma3d_set_t s);
        @(negedge clk);
        ld_valid = 1'b1; ld_idx = idx; ld_data = s;
        @(negedge clk);
        ld_valid = 1'b0;
        if (idx == 3'd7) begin mset = s; mb = 0; mc = 0; end
        else mtbl[idx] = s;
    endtask

    task automatic start_sync(output bit miss_exp, output int want);
        want = burst_len();
        miss_exp = (want == 0);
        @(negedge clk); ev_sync = 1'b1;
        @(negedge clk); ev_sync = 1'b0;
        chk(ev_miss == miss_exp, "R11", $sformatf("ev_miss got %0b exp %0b", ev_miss, miss_exp));
        chk(out_valid == !miss_exp, "R12", $sformatf("out_valid got %0b exp %0b", out_valid, !miss_exp));
    endtask

    task automatic drain(input int want, output int errs);
        int got = 0;
        bit chain_exp = 0;
        logic [5:0] ch_exp = '0;
        logic [31:0] es, ed;
        string tag;
        errs = 0;
        while (got < want) begin
            out_ready = ($urandom % 4) != 0;
            if (out_valid && out_ready) begin
                es = exp_addr(mset.src_addr, mset.src_aofs, mset.src_fofs, mset.src_fix, mb, mc);
                ed = exp_addr(mset.dst_addr, mset.dst_aofs, mset.dst_fofs, mset.dst_fix, mb, mc);
                tag = (mset.src_fix || mset.dst_fix) ? "R6" : ((mc > 0) ? "R5" : "R4");
                if (out_src != es || out_dst != ed) errs++;
                chk(out_src == es, tag, $sformatf("src got %h exp %h", out_src, es));
                chk(out_dst == ed, tag, $sformatf("dst got %h exp %h", out_dst, ed));
                chk(out_len == mset.arr_bytes, "R3", $sformatf("len got %0d exp %0d", out_len, mset.arr_bytes));
                got++; mb++;
                if (mb == int'(mset.frm_arrays)) begin
                    mb = 0; mc++;
                    if (mc == int'(mset.blk_frames)) begin
                        chain_exp = mset.chain_en;
                        ch_exp = mset.chain_ch;
                        mc = 0;
                        mset = (mset.link == 3'd7) ? dma3d_set_t'('0) : mtbl[mset.link];
                    end
                end
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(!out_valid, "R7", $sformatf("out_valid after burst got %0b exp 0", out_valid));
        chk(chain_vld == chain_exp, "R10", $sformatf("chain_vld got %0b exp %0b", chain_vld, chain_exp));
        if (chain_exp)
            chk(chain_ch == ch_exp, "R10", $sformatf("chain_ch got %0d exp %0d", chain_ch, ch_exp));
        @(negedge clk);
        chk(!chain_vld, "R10", $sformatf("chain_vld second cycle got %0b exp 0", chain_vld));
    endtask

    task automatic do_sync();
        bit m; int w; int e;
        start_sync(m, w);
        if (!m) drain(w, e);
    endtask

    initial begin
        dma3d_set_t sa, sb, sc;
        bit m; int w; int e;
        logic [31:0] held;
        void'($urandom(32'd20240611));
        mset = '0;
        for (int i = 0; i < TBL_DEPTH; i++) mtbl[i] = '0;
        repeat (4) @(negedge clk);
        chk(!out_valid && !ev_miss && !chain_vld, "R1", $sformatf("in reset v=%0b m=%0b c=%0b exp 0", out_valid, ev_miss, chain_vld));
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !ev_miss && !chain_vld, "R1", $sformatf("after reset v=%0b m=%0b c=%0b exp 0", out_valid, ev_miss, chain_vld));
        start_sync(m, w);
        chk(ev_miss == 1'b1, "R1", $sformatf("sync after reset miss got %0b exp 1", ev_miss));

        // Directed: per-array sync, negative dst offset, link to entry 2, no chain.
        sa = '0;
        sa.src_addr = 32'h1000_0000; sa.dst_addr = 32'h2000_0100;
        sa.arr_bytes = 16; sa.frm_arrays = 3; sa.blk_frames = 2;
        sa.src_aofs = 16'h0040; sa.src_fofs = 16'h1000;
        sa.dst_aofs = 16'hFFF0; sa.dst_fofs = 16'h0200;
        sa.link = 3'd2; sa.mode = SYNC_ARRAY; sa.chain_en = 1'b0;
        sb = '0;
        sb.src_addr = 32'h3000_0000; sb.dst_addr = 32'h4000_0000;
        sb.arr_bytes = 8; sb.frm_arrays = 2; sb.blk_frames = 2;
        sb.dst_aofs = 16'h0008; sb.dst_fofs = 16'h0100; sb.src_aofs = 16'h7777;
        sb.src_fix = 1'b1; sb.link = 3'd7; sb.mode = SYNC_FRAME;
        sb.chain_en = 1'b1; sb.chain_ch = 6'd5;
        load(3'd7, sa);
        do_sync();
        load(3'd2, sb);
        start_sync(m, w);
        drain(w, e);
        chk(e == 0, "R2", $sformatf("table write disturbed active walk, %0d bad beats exp 0", e));
        repeat (4) do_sync();
        // Now running the linked set (frame mode, fixed source).
        do_sync();
        do_sync();
        start_sync(m, w);
        chk(m && ev_miss, "R9", $sformatf("after null link miss got %0b exp 1", ev_miss));

        // Directed: stall and sync while busy.
        sc = '0;
        sc.src_addr = 32'h0000_8000; sc.dst_addr = 32'h0001_0000;
        sc.arr_bytes = 4; sc.frm_arrays = 2; sc.blk_frames = 2;
        sc.src_aofs = 16'h0004; sc.dst_aofs = 16'h0004; sc.src_fofs = 16'h0100; sc.dst_fofs = 16'hFF00;
        sc.link = 3'd7; sc.mode = SYNC_BLOCK; sc.chain_en = 1'b1; sc.chain_ch = 6'd33;
        load(3'd7, sc);
        start_sync(m, w);
        out_ready = 1'b0;
        held = out_src;
        @(negedge clk);
        chk(out_valid && out_src == held, "R8", $sformatf("stalled src got %h exp %h", out_src, held));
        ev_sync = 1'b1;
        @(negedge clk);
        ev_sync = 1'b0;
        chk(ev_miss == 1'b1, "R11", $sformatf("busy sync miss got %0b exp 1", ev_miss));
        chk(out_valid && out_src == held, "R8", $sformatf("after busy sync src got %h exp %h", out_src, held));
        drain(w, e);

        // Random scenarios.
        for (int s = 0; s < 40; s++) begin
            for (int i = 0; i < TBL_DEPTH; i++) load(3'(i), rand_set());
            load(3'd7, rand_set());
            for (int k = 0; k < 10; k++) do_sync();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete, got timeout exp finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule